// File: doc/BRIEF.md
# Flash Program/Erase Engine with Erase Suspend

This block is the automation core behind a 16-bit NOR-style flash array. It carries out block erase and single-word programming, checks supply and protection before it starts, and reports results through an 8-bit status byte and a ready/busy line. It drives a behavioural array through a simple write port: address, data and strobe, with a combinational read-back path. The address space has an asymmetric layout. It starts with two small boot blocks at the bottom, then six small parameter blocks, then fifteen large main blocks. With the default sizes, small blocks hold 4K words, large blocks hold 32K words, and the array holds 512K words.

An erase waits through a preparation interval and then sweeps the addressed block, writing the all-ones word once per cycle. A program operation waits a fixed number of cycles and then stores the old word ANDed with the new data, so it can only clear bits. The preparation and program times are separate for small and large blocks. A suspend request parks a running erase after a fixed latency. While the erase is parked, one word may be programmed elsewhere, and a resume request continues the erase from the word where it stopped. A synchronous reset aborts any operation immediately and leaves whatever part of a block was already swept.

Top module: `nvm_program_engine`

## Requirements
- R1: Blocks are laid out from address 0 upward: N_BOOT boot blocks of SMALL_WORDS, then N_PARAM parameter blocks of SMALL_WORDS, then N_MAIN main blocks of BIG_WORDS. An erase changes only the words of the block that contains the request address.
- R2: A successful erase leaves every word of the addressed block at all ones (FFFFh).
- R3: A successful program stores (old word AND request data) at the request address.
- R4: A start request with `vpp_ok` low sets status bit 3 together with bit 5 (erase) or bit 4 (program). It does not start an operation and does not alter the array.
- R5: A start request into a boot block with both `boot_wp_release` and `hv_override` low sets status bit 1 together with bit 5 or bit 4, and leaves the array unchanged. Raising either input unlocks the boot blocks. Parameter and main blocks are never locked.
- R6: Status layout: bit 7 ready, bit 6 erase parked, bit 5 erase error, bit 4 program error, bit 3 supply low, bit 1 boot lock, bits 2 and 0 zero. Bits 5, 4, 3 and 1 accumulate across operations. They are cleared only by `clear_req` while the engine is idle, and `clear_req` has no effect while the erase is parked.
- R7: `rdy_busy` and status bit 7 are low only while an erase or program is running. They are high when idle, while parked and while `rst_n` is low.
- R8: A `suspend_req` during a running erase parks it exactly SUSP_LAT cycles after the request edge. From then on status reads C0h (plus any error bits) and `rdy_busy` is high.
- R9: A program started while the erase is parked drives status bit 7 and `rdy_busy` low while it runs and keeps bit 6 set. When it finishes, the engine returns to the parked state.
- R10: `resume_req` while parked continues the erase to completion. Afterwards the whole block is erased and bit 6 is clear.
- R11: While `rst_n` is low at a clock edge, a running operation stops writing at once. The words already swept stay erased, the rest keep their old data, and status reads 80h afterwards.
- R12: When `inj_prog_fail` is high in the final cycle of a program, status bit 4 is set and the word is not written.
- R13: Start requests received while an operation is running are ignored.
- R14: A program into a small block keeps `rdy_busy` low for WRITE_SMALL_CYC cycles, and into a main block for WRITE_BIG_CYC cycles. An erase lasts ERASE_SMALL_CYC or ERASE_BIG_CYC cycles plus one cycle per word of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; aborts operations |
| start_erase | input | 1 | Request a block erase at `req_addr` |
| start_write | input | 1 | Request a word program at `req_addr` with `req_data` |
| suspend_req | input | 1 | Request parking of a running erase |
| resume_req | input | 1 | Continue a parked erase |
| clear_req | input | 1 | Clear the accumulated error bits |
| req_addr | input | ADDR_W | Word address of a request |
| req_data | input | DATA_W | Data of a program request |
| vpp_ok | input | 1 | Programming supply valid |
| boot_wp_release | input | 1 | High permits altering boot blocks |
| hv_override | input | 1 | High-voltage reset level; also unlocks boot blocks |
| inj_prog_fail | input | 1 | Fault injection: fail the finishing program |
| arr_rdata | input | DATA_W | Array read data at `arr_addr` |
| status | output | 8 | Status byte |
| rdy_busy | output | 1 | High when ready, low while an operation runs |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array word address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The bench builds the engine with 16-word small blocks and 128-word main blocks, a 2048-word array in total. With these sizes a whole-block erase sweep finishes in well under two hundred cycles, so an erase can be parked, resumed or aborted in the middle of its sweep, and the partially erased block can be compared against a full array model. The preparation and program counts are short and differ between small and main blocks (5/20 and 4/6 cycles). Measuring how long `rdy_busy` stays low therefore shows which block class the address map selected. A suspend latency of 3 makes the exact parking edge observable.

// File: rtl/nvm_eng_pkg.sv
// Package: shared state encoding, status bit positions and helpers for the
// program/erase engine. Assumes nothing beyond plain SystemVerilog.
package nvm_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EDWELL,
        ST_ESWEEP,
        ST_ESUSP,
        ST_WRUN
    } eng_state_t;

    localparam int unsigned SRB_READY = 7;
    localparam int unsigned SRB_PARK  = 6;
    localparam int unsigned SRB_EERR  = 5;
    localparam int unsigned SRB_WERR  = 4;
    localparam int unsigned SRB_VLOW  = 3;
    localparam int unsigned SRB_LOCK  = 1;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvm_block_map.sv
// Block map: turns a word address into its block base, its size class and a
// boot flag. Assumes bottom-boot order (boot, parameter, main) and power-of-two
// block sizes.
module nvm_block_map #(
    parameter int unsigned SMALL_WORDS = 4096,
    parameter int unsigned BIG_WORDS   = 32768,
    parameter int unsigned N_BOOT      = 2,
    parameter int unsigned N_PARAM     = 6,
    parameter int unsigned ADDR_W      = 19
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_boot,
    output logic              is_big,
    output logic [ADDR_W-1:0] base
);
    localparam logic [ADDR_W-1:0] BOOT_END  = ADDR_W'(N_BOOT * SMALL_WORDS);
    localparam logic [ADDR_W-1:0] SMALL_END = ADDR_W'((N_BOOT + N_PARAM) * SMALL_WORDS);
    localparam logic [ADDR_W-1:0] SMALL_MSK = ~ADDR_W'(SMALL_WORDS - 1);
    localparam logic [ADDR_W-1:0] BIG_MSK   = ~ADDR_W'(BIG_WORDS - 1);

    logic [ADDR_W-1:0] big_off;

    // Classify the address and align it down to the start of its block.
    always_comb begin
        is_boot = addr < BOOT_END;
        is_big  = addr >= SMALL_END;
        big_off = addr - SMALL_END;
        if (is_big) base = SMALL_END + (big_off & BIG_MSK);
        else        base = addr & SMALL_MSK;
    end
endmodule

// File: rtl/nvm_countdown.sv
// Down-counter timer: load a value, count down while enabled, hold at zero.
// Assumes the loaded value is the wanted cycle count minus one.
module nvm_countdown #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         en,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load has priority; otherwise decrement until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= val;
        else if (en && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nvm_program_engine.sv
// Program/erase engine: runs block erase (preparation wait, then one word per
// cycle set to all ones) and word program (wait, then old AND new), with
// supply and boot-lock checks, erase park/resume with a nested program, and
// sticky error bits. Assumes a combinational array read port and synchronous
// active-low reset that aborts any operation.
module nvm_program_engine
    import nvm_eng_pkg::*;
#(
    parameter int unsigned SMALL_WORDS     = 4096,
    parameter int unsigned BIG_WORDS       = 32768,
    parameter int unsigned N_BOOT          = 2,
    parameter int unsigned N_PARAM         = 6,
    parameter int unsigned N_MAIN          = 15,
    parameter int unsigned DATA_W          = 16,
    parameter int unsigned ERASE_SMALL_CYC = 64,
    parameter int unsigned ERASE_BIG_CYC   = 256,
    parameter int unsigned WRITE_SMALL_CYC = 12,
    parameter int unsigned WRITE_BIG_CYC   = 8,
    parameter int unsigned SUSP_LAT        = 6,
    localparam int unsigned ADDR_W = $clog2((N_BOOT + N_PARAM) * SMALL_WORDS + N_MAIN * BIG_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_erase,
    input  logic              start_write,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              clear_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              vpp_ok,
    input  logic              boot_wp_release,
    input  logic              hv_override,
    input  logic              inj_prog_fail,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [7:0]        status,
    output logic              rdy_busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int unsigned MAX_CYC = imax(imax(ERASE_SMALL_CYC, ERASE_BIG_CYC),
                                           imax(imax(WRITE_SMALL_CYC, WRITE_BIG_CYC), SUSP_LAT));
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam int unsigned IDX_W   = $clog2(BIG_WORDS);
    localparam int unsigned N_TMR   = 3;   // 0: erase preparation, 1: program, 2: park latency

    eng_state_t        st, e_ret;
    logic [ADDR_W-1:0] e_base, w_addr;
    logic [IDX_W-1:0]  e_idx;
    logic              e_big, w_nest, susp_pend;
    logic [DATA_W-1:0] w_data;
    logic              sr_e, sr_w, sr_v, sr_l;

    logic              map_boot, map_big;
    logic [ADDR_W-1:0] map_base;
    logic              bad_vpp, bad_lock, start_bad;
    logic              er_accept, er_reject, wr_accept, wr_reject, susp_take;
    logic              e_last, running;
    logic [N_TMR-1:0]  t_load, t_en, t_zero;
    logic [CNT_W-1:0]  t_val [N_TMR];

    nvm_block_map #(
        .SMALL_WORDS(SMALL_WORDS), .BIG_WORDS(BIG_WORDS),
        .N_BOOT(N_BOOT), .N_PARAM(N_PARAM), .ADDR_W(ADDR_W)
    ) u_map (
        .addr(req_addr), .is_boot(map_boot), .is_big(map_big), .base(map_base)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        nvm_countdown #(.W(CNT_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .load(t_load[g]), .val(t_val[g]),
            .en(t_en[g]), .zero(t_zero[g])
        );
    end

    // Request qualification: supply and boot-lock checks, accept/reject decode.
    always_comb begin
        bad_vpp   = !vpp_ok;
        bad_lock  = map_boot && !boot_wp_release && !hv_override;
        start_bad = bad_vpp || bad_lock;
        er_accept = (st == ST_IDLE) && start_erase && !start_bad;
        er_reject = (st == ST_IDLE) && start_erase && start_bad;
        wr_accept = start_write && !start_bad &&
                    (((st == ST_IDLE) && !start_erase) || ((st == ST_ESUSP) && !resume_req));
        wr_reject = start_write && start_bad &&
                    (((st == ST_IDLE) && !start_erase) || ((st == ST_ESUSP) && !resume_req));
        e_last    = e_idx == (e_big ? IDX_W'(BIG_WORDS - 1) : IDX_W'(SMALL_WORDS - 1));
        susp_take = suspend_req && !susp_pend &&
                    ((st == ST_EDWELL) || ((st == ST_ESWEEP) && !e_last));
        running   = (st == ST_EDWELL) || (st == ST_ESWEEP) || (st == ST_WRUN);
    end

    // Timer controls: load on the accepting edge, count in the matching state.
    always_comb begin
        t_load[0] = er_accept;
        t_val[0]  = map_big ? CNT_W'(ERASE_BIG_CYC - 1) : CNT_W'(ERASE_SMALL_CYC - 1);
        t_en[0]   = (st == ST_EDWELL);
        t_load[1] = wr_accept;
        t_val[1]  = map_big ? CNT_W'(WRITE_BIG_CYC - 1) : CNT_W'(WRITE_SMALL_CYC - 1);
        t_en[1]   = (st == ST_WRUN);
        t_load[2] = susp_take;
        t_val[2]  = CNT_W'(SUSP_LAT - 1);
        t_en[2]   = susp_pend;
    end

    // Main sequencer: state, latched operands and sticky error bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            e_ret     <= ST_EDWELL;
            e_base    <= '0;
            e_idx     <= '0;
            e_big     <= 1'b0;
            w_addr    <= '0;
            w_data    <= '0;
            w_nest    <= 1'b0;
            susp_pend <= 1'b0;
            sr_e      <= 1'b0;
            sr_w      <= 1'b0;
            sr_v      <= 1'b0;
            sr_l      <= 1'b0;
        end else begin
            if (er_reject || wr_reject) begin
                sr_e <= sr_e | er_reject;
                sr_w <= sr_w | wr_reject;
                sr_v <= sr_v | bad_vpp;
                sr_l <= sr_l | bad_lock;
            end
            if (wr_accept) begin
                w_addr <= req_addr;
                w_data <= req_data;
                w_nest <= (st == ST_ESUSP);
                st     <= ST_WRUN;
            end
            if (susp_take) susp_pend <= 1'b1;
            case (st)
                ST_IDLE: begin
                    if (er_accept) begin
                        e_base <= map_base;
                        e_big  <= map_big;
                        e_idx  <= '0;
                        st     <= ST_EDWELL;
                    end else if (!start_erase && !start_write && clear_req) begin
                        sr_e <= 1'b0;
                        sr_w <= 1'b0;
                        sr_v <= 1'b0;
                        sr_l <= 1'b0;
                    end
                end
                ST_EDWELL: begin
                    if (susp_pend && t_zero[2]) begin
                        st        <= ST_ESUSP;
                        e_ret     <= ST_EDWELL;
                        susp_pend <= 1'b0;
                    end else if (t_zero[0]) begin
                        st <= ST_ESWEEP;
                    end
                end
                ST_ESWEEP: begin
                    if (e_last) begin
                        st        <= ST_IDLE;
                        susp_pend <= 1'b0;
                    end else begin
                        e_idx <= e_idx + 1'b1;
                        if (susp_pend && t_zero[2]) begin
                            st        <= ST_ESUSP;
                            e_ret     <= ST_ESWEEP;
                            susp_pend <= 1'b0;
                        end
                    end
                end
                ST_ESUSP: begin
                    if (resume_req) st <= e_ret;
                end
                ST_WRUN: begin
                    if (t_zero[1]) begin
                        if (inj_prog_fail) sr_w <= 1'b1;
                        st <= w_nest ? ST_ESUSP : ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Array port: sweep writes all ones, program writes old AND new at the end.
    always_comb begin
        arr_we    = rst_n && ((st == ST_ESWEEP) ||
                              ((st == ST_WRUN) && t_zero[1] && !inj_prog_fail));
        arr_addr  = (st == ST_WRUN) ? w_addr : (e_base + ADDR_W'(e_idx));
        arr_wdata = (st == ST_WRUN) ? (arr_rdata & w_data) : '1;
    end

    // Status byte and ready/busy line.
    always_comb begin
        status            = '0;
        status[SRB_READY] = !running;
        status[SRB_PARK]  = (st == ST_ESUSP) || ((st == ST_WRUN) && w_nest);
        status[SRB_EERR]  = sr_e;
        status[SRB_WERR]  = sr_w;
        status[SRB_VLOW]  = sr_v;
        status[SRB_LOCK]  = sr_l;
        rdy_busy          = !rst_n || !running;
    end
endmodule

// File: rtl/nvm_engine_chk.sv
// Checker: temporal properties of the program/erase engine, observed at its
// ports. Assumes synchronous active-low reset on rst_n.
module nvm_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_write,
    input logic       clear_req,
    input logic       resume_req,
    input logic       vpp_ok,
    input logic [7:0] status,
    input logic       rdy_busy,
    input logic       arr_we
);
    // R7: the ready pin follows status bit 7 outside reset.
    p_rdy_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_busy == status[7]);

    // R7: the array is written only while an operation runs.
    p_write_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !rdy_busy);

    // R6: the erase error bit holds until a clear request.
    p_sticky_eerr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !clear_req) |=> status[5]);

    // R9: the parked flag stays set until resume is requested.
    p_park_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !resume_req) |=> status[6]);

    // R8: entering the parked state sets ready in the same cycle.
    p_park_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> status[7]);

    // R4: a program request without supply flags low supply and starts nothing.
    p_vpp_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_write && !vpp_ok && status[7]) |=> (status[3] && status[7] && !arr_we));

    // R11: ready is high whenever reset is held.
    always_comb begin
        if (!rst_n) begin
            p_rdy_in_reset_r11: assert (rdy_busy);
        end
    end
endmodule

bind nvm_program_engine nvm_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_write(start_write), .clear_req(clear_req),
    .resume_req(resume_req), .vpp_ok(vpp_ok), .status(status),
    .rdy_busy(rdy_busy), .arr_we(arr_we)
);

// File: tb/sim_nvm_program_engine.sv
// Bench for the program/erase engine: a vector table of program requests
// walked by one loop, then directed erase, park, resume and reset tests.
module sim_nvm_program_engine;
    localparam int CLK_PERIOD = 10;
    localparam int SMALL = 16;
    localparam int BIG   = 128;
    localparam int NBOOT = 2;
    localparam int NPAR  = 6;
    localparam int NMAIN = 15;
    localparam int ES = 5, EB = 20, WS = 4, WB = 6, LAT = 3;
    localparam int TOTAL = (NBOOT + NPAR) * SMALL + NMAIN * BIG;
    localparam int SMALL_END = (NBOOT + NPAR) * SMALL;
    localparam int AW = $clog2(TOTAL);

    // {addr[63:48], data[47:32], ctl[31:24] = {4'b0, wp, hv, vpp, fault}, sr[23:16], word[15:0]}
    localparam logic [63:0] VEC [9] = '{
        64'h0200_1234_02_80_1234,
        64'h0200_00FF_02_80_0034,
        64'h0005_0000_02_92_FFFF,
        64'h0005_A5A5_0A_80_A5A5,
        64'h0014_1357_06_80_1357,
        64'h0028_2468_02_80_2468,
        64'h0300_0000_00_98_FFFF,
        64'h0018_0000_00_9A_FFFF,
        64'h0400_0F0F_03_90_FFFF
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_erase = 1'b0, start_write = 1'b0, suspend_req = 1'b0;
    logic          resume_req = 1'b0, clear_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic          vpp_ok = 1'b1, boot_wp_release = 1'b0, hv_override = 1'b0;
    logic          inj_prog_fail = 1'b0;
    logic [15:0]   arr_rdata;
    logic [7:0]    status;
    logic          rdy_busy, arr_we;
    logic [AW-1:0] arr_addr;
    logic [15:0]   arr_wdata;
    logic [15:0]   mem [0:TOTAL-1];
    int            n_chk = 0;
    int            n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;
    assign arr_rdata = mem[arr_addr];

    nvm_program_engine #(
        .SMALL_WORDS(SMALL), .BIG_WORDS(BIG), .N_BOOT(NBOOT), .N_PARAM(NPAR),
        .N_MAIN(NMAIN), .DATA_W(16), .ERASE_SMALL_CYC(ES), .ERASE_BIG_CYC(EB),
        .WRITE_SMALL_CYC(WS), .WRITE_BIG_CYC(WB), .SUSP_LAT(LAT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_erase(start_erase), .start_write(start_write),
        .suspend_req(suspend_req), .resume_req(resume_req), .clear_req(clear_req),
        .req_addr(req_addr), .req_data(req_data), .vpp_ok(vpp_ok),
        .boot_wp_release(boot_wp_release), .hv_override(hv_override),
        .inj_prog_fail(inj_prog_fail), .arr_rdata(arr_rdata), .status(status),
        .rdy_busy(rdy_busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind: 0 erase, 1 program, 2 suspend, 3 resume, 4 clear; one sampled edge.
    task automatic issue(input int kind, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        req_addr    = a[AW-1:0];
        req_data    = d;
        start_erase = (kind == 0);
        start_write = (kind == 1);
        suspend_req = (kind == 2);
        resume_req  = (kind == 3);
        clear_req   = (kind == 4);
        @(posedge clk);
        @(negedge clk);
        {start_erase, start_write, suspend_req, resume_req, clear_req} = '0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!rdy_busy && n < 5000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic all_ff;
        for (int i = 0; i < TOTAL; i++) mem[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset status", 32'(status), 32'h80);
        check("R7 reset ready", 32'(rdy_busy), 32'h1);

        // Vector loop: program requests under varied supply/lock/fault inputs.
        for (int v = 0; v < 9; v++) begin
            logic [63:0] e;
            int exp_n;
            e = VEC[v];
            {boot_wp_release, hv_override, vpp_ok, inj_prog_fail} = e[27:24];
            issue(4, 16'h0, 16'h0);
            issue(1, e[63:48], e[47:32]);
            wait_ready(n);
            if (e[23:16] == 8'h80 || e[24])
                exp_n = (int'(e[63:48]) >= SMALL_END) ? WB : WS;
            else
                exp_n = 0;
            check($sformatf("R14 vec%0d busy cycles", v), 32'(n), 32'(exp_n));
            check($sformatf("R3 R4 R5 R12 vec%0d status", v), 32'(status), 32'(e[23:16]));
            check($sformatf("R3 R4 R5 R12 vec%0d word", v), 32'(mem[e[63:48]]), 32'(e[15:0]));
        end
        {boot_wp_release, hv_override, vpp_ok, inj_prog_fail} = 4'b0010;
        issue(4, 16'h0, 16'h0);

        // R1 R2: erase one parameter block, neighbour untouched.
        issue(1, 16'h0030, 16'h1111);
        wait_ready(n);
        issue(0, 16'h002D, 16'h0);
        wait_ready(n);
        check("R14 small erase cycles", 32'(n), 32'(ES + SMALL));
        all_ff = 1'b1;
        for (int i = 32; i < 48; i++) if (mem[i] !== 16'hFFFF) all_ff = 1'b0;
        check("R2 parameter block erased", 32'(all_ff), 32'h1);
        check("R1 next block kept", 32'(mem[48]), 32'h1111);
        check("R1 erase status", 32'(status), 32'h80);

        // R5 R6: locked boot erase, then supply-low program, accumulating.
        issue(0, 16'h0005, 16'h0);
        check("R5 boot erase locked status", 32'(status), 32'hA2);
        check("R5 boot data kept", 32'(mem[5]), 32'hA5A5);
        vpp_ok = 1'b0;
        issue(1, 16'h0300, 16'h0);
        check("R6 bits accumulate", 32'(status), 32'hBA);
        vpp_ok = 1'b1;
        issue(4, 16'h0, 16'h0);
        check("R6 clear when idle", 32'(status), 32'h80);

        // R8 R9 R10 R13: park a main-block erase, nested program, resume.
        issue(0, 16'h0240, 16'h0);
        repeat (EB + 10) @(negedge clk);
        issue(1, 16'h0100, 16'h0000);
        check("R13 busy during erase", 32'(rdy_busy), 32'h0);
        issue(2, 16'h0, 16'h0);
        wait_ready(n);
        check("R8 park latency", 32'(n), 32'(LAT));
        check("R8 parked status", 32'(status), 32'hC0);
        vpp_ok = 1'b0;
        issue(1, 16'h0300, 16'h0);
        vpp_ok = 1'b1;
        issue(4, 16'h0, 16'h0);
        check("R6 clear ignored while parked", 32'(status), 32'hD8);
        issue(1, 16'h0100, 16'h4321);
        check("R9 nested status", 32'(status), 32'h58);
        check("R9 nested busy", 32'(rdy_busy), 32'h0);
        wait_ready(n);
        check("R14 nested program cycles", 32'(n), 32'(WB));
        check("R9 back to parked", 32'(status), 32'hD8);
        check("R13 ignored request did not land", 32'(mem[16'h0100]), 32'h4321);
        issue(3, 16'h0, 16'h0);
        wait_ready(n);
        all_ff = 1'b1;
        for (int i = 16'h0200; i < 16'h0280; i++) if (mem[i] !== 16'hFFFF) all_ff = 1'b0;
        check("R10 resumed erase complete", 32'(all_ff), 32'h1);
        check("R10 status after resume", 32'(status), 32'h98);
        issue(4, 16'h0, 16'h0);

        // R11: abort a main-block erase mid-sweep.
        issue(1, 16'h0300, 16'h0000);
        wait_ready(n);
        issue(1, 16'h037F, 16'h0000);
        wait_ready(n);
        issue(0, 16'h0310, 16'h0);
        repeat (EB + 40) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 ready during reset", 32'(rdy_busy), 32'h1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 status after abort", 32'(status), 32'h80);
        check("R11 swept word erased", 32'(mem[16'h0300]), 32'hFFFF);
        check("R11 unswept word kept", 32'(mem[16'h037F]), 32'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule